// File: doc/BRIEF.md
# Phase-Count and Conduction-Mode Selector

This block decides how a multi-phase step-down regulator runs. On every evaluation
tick it compares a digitized average load-current word, in milliamps, with four
code-selected thresholds. From that comparison it chooses between pulse-frequency
operation (PFM), meant for light loads, and pulse-width operation (PWM), meant for
heavier loads. While in PWM it also sets how many of up to six phases conduct.

Each decision uses its own pair of thresholds. Leaving PFM uses one level and returning
to it uses another. Adding a phase uses one per-phase level and shedding a phase uses
another. This hysteresis, together with a qualification filter that needs a condition
to hold on a run of consecutive ticks, keeps the outputs from chattering. A forced-PWM
input overrides the load-based choice of mode. Deasserting enable returns the selector
to its idle state.

The block is meant to sit between a current-sense digitizer and the power-stage
sequencing logic. Configuration codes arrive as plain inputs.

Top module: `phase_mode_ctrl`

## Requirements
- R1: After reset the outputs show one phase in PFM (pwm_mode=0, phase_cnt=1). While enable is low, the cycle after each clock edge shows phase_cnt=1 and pwm_mode equal to force_pwm, and ticks have no effect.
- R2: When force_pwm is high, pwm_mode is 1 from the next cycle on, whatever the load. The mode stays PWM while force_pwm stays high.
- R3: In PFM, a tick counts towards leaving PFM when load_ma is strictly above the exit threshold. Exit codes 011, 100, 101, 110 and 111 select 175, 225, 275, 325 and 375 mA. Codes 000 to 010 select 175 mA. On the 16th consecutive counting tick, pwm_mode becomes 1 with phase_cnt=1.
- R4: In PWM with force_pwm low, a tick counts towards returning to PFM when load_ma is strictly below the entry threshold. Entry codes 000 to 100 select 100, 125, 150, 175 and 225 mA. Codes 101 to 111 select 225 mA. On the 16th consecutive counting tick, pwm_mode becomes 0 and phase_cnt becomes 1.
- R5: A tick on which a condition does not hold restarts its count. Cycles without a tick neither advance nor restart a count. Outputs change only in the cycle after a tick, except for the changes that R1 and R2 describe.
- R6: In PWM with n active phases, a tick counts towards adding a phase when n<6 and floor(load_ma/n) is strictly above the add threshold. Add code k selects 300+100*k mA for k from 2 to 7, and codes 000 and 001 select 500 mA. On the 16th consecutive counting tick, phase_cnt becomes n+1.
- R7: In PWM with n active phases, a tick counts towards shedding a phase when n>1 and floor(load_ma/n) is strictly below the shed threshold. Shed code k selects 300+100*k mA for k from 0 to 5, and codes 110 and 111 select 800 mA. On the 16th consecutive counting tick, phase_cnt becomes n-1.
- R8: phase_cnt always lies between 1 and 6 and moves by one per qualified event. A change of phase count restarts both phase counts. When an add and a shed qualify on the same tick, the add wins. When a mode change qualifies, it takes precedence over both.
- R9: In PFM, phase_cnt is 1, and the phase counts stay cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Selector enable; low forces the idle state |
| tick | input | 1 | Evaluation strobe; load_ma is sampled while high |
| force_pwm | input | 1 | Hold the converter in PWM regardless of load |
| load_ma | input | 14 | Average total load current in mA |
| exit_sel | input | 3 | PFM-to-PWM threshold code |
| entry_sel | input | 3 | PWM-to-PFM threshold code |
| add_sel | input | 3 | Per-phase phase-add threshold code |
| shed_sel | input | 3 | Per-phase phase-shed threshold code |
| pwm_mode | output | 1 | 1 = PWM, 0 = PFM |
| phase_cnt | output | 3 | Number of active phases, 1 to 6 |

## Verification
The bench builds the block with its default parameters: six phases, a 14-bit load word and a 16-tick qualification window. With these values the phase count can climb all the way to its ceiling and fall back within a short run. The tests cover counts of 15 and 16 ticks, exact-threshold loads (175 mA against exit, 300 and 500 mA per phase), every reserved-code clamp, an add and a shed qualifying on the same tick, and a mode return that coincides with a shed. Each result is compared against an independent tick-level model of the requirements.

// File: rtl/phase_mode_pkg.sv
package phase_mode_pkg;

    // Width of a decoded threshold in mA (largest value is 1000)
    localparam int TH_W = 11;

    // Qualification filter slots
    localparam int FLT_MODE = 0;
    localparam int FLT_ADD  = 1;
    localparam int FLT_SHED = 2;
    localparam int N_FLT    = 3;

    typedef struct packed {
        logic [TH_W-1:0] exit_ma;   // leave PFM above this
        logic [TH_W-1:0] entry_ma;  // return to PFM below this
        logic [TH_W-1:0] add_ma;    // per-phase add level
        logic [TH_W-1:0] shed_ma;   // per-phase shed level
    } thresholds_t;

    // 175 mA + 50 mA per code step from code 3; lower codes clamp to 3
    function automatic logic [TH_W-1:0] dec_exit(input logic [2:0] code);
        logic [2:0] k;
        k = (code < 3'd3) ? 3'd3 : code;
        return TH_W'(175) + TH_W'(k - 3'd3) * TH_W'(50);
    endfunction

    // 100 mA + 25 mA per step up to code 3, code 4 is 225 mA; higher clamp to 4
    function automatic logic [TH_W-1:0] dec_entry(input logic [2:0] code);
        logic [2:0] k;
        k = (code > 3'd4) ? 3'd4 : code;
        if (k == 3'd4)
            return TH_W'(225);
        return TH_W'(100) + TH_W'(k) * TH_W'(25);
    endfunction

    // 300 mA + 100 mA per step; codes below 2 clamp to 2
    function automatic logic [TH_W-1:0] dec_add(input logic [2:0] code);
        logic [2:0] k;
        k = (code < 3'd2) ? 3'd2 : code;
        return TH_W'(300) + TH_W'(k) * TH_W'(100);
    endfunction

    // 300 mA + 100 mA per step; codes above 5 clamp to 5
    function automatic logic [TH_W-1:0] dec_shed(input logic [2:0] code);
        logic [2:0] k;
        k = (code > 3'd5) ? 3'd5 : code;
        return TH_W'(300) + TH_W'(k) * TH_W'(100);
    endfunction

endpackage

// File: rtl/thr_decode.sv
module thr_decode
    import phase_mode_pkg::*;
(
    input  logic [2:0]  exit_sel,
    input  logic [2:0]  entry_sel,
    input  logic [2:0]  add_sel,
    input  logic [2:0]  shed_sel,
    output thresholds_t thr
);

    always_comb begin
        thr.exit_ma  = dec_exit(exit_sel);
        thr.entry_ma = dec_entry(entry_sel);
        thr.add_ma   = dec_add(add_sel);
        thr.shed_ma  = dec_shed(shed_sel);
    end

endmodule

// File: rtl/phase_scaler.sv
// Turns per-phase thresholds into total-current limits for n phases, so
// that floor(load/n) > add  <=> load >= (add+1)*n
// and floor(load/n) < shed <=> load <  shed*n
module phase_scaler
    import phase_mode_pkg::*;
#(
    parameter int PH_W  = 3,
    parameter int CMP_W = 15
) (
    input  logic [TH_W-1:0]  add_ma,
    input  logic [TH_W-1:0]  shed_ma,
    input  logic [PH_W-1:0]  n_phases,
    output logic [CMP_W-1:0] add_lim,
    output logic [CMP_W-1:0] shed_lim
);

    always_comb begin
        add_lim  = (CMP_W'(add_ma) + CMP_W'(1)) * CMP_W'(n_phases);
        shed_lim = CMP_W'(shed_ma) * CMP_W'(n_phases);
    end

endmodule

// File: rtl/qual_filter.sv
// Counts consecutive ticks on which req holds; fires on the last one.
// block: clears the count and suppresses fire.
// restart: clears the count without touching this cycle's fire.
module qual_filter #(
    parameter int QUAL_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic req,
    input  logic block,
    input  logic restart,
    output logic fire
);

    localparam int CW = $clog2(QUAL_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(QUAL_TICKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        fire  = !block && tick && req && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (block || restart || fire)
            cnt_d = '0;
        else if (tick)
            cnt_d = req ? cnt_q + CW'(1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

endmodule

// File: rtl/phase_mode_ctrl.sv
module phase_mode_ctrl
    import phase_mode_pkg::*;
#(
    parameter int LOAD_W     = 14,
    parameter int MAX_PHASES = 6,
    parameter int QUAL_TICKS = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              enable,
    input  logic                              tick,
    input  logic                              force_pwm,
    input  logic [LOAD_W-1:0]                 load_ma,
    input  logic [2:0]                        exit_sel,
    input  logic [2:0]                        entry_sel,
    input  logic [2:0]                        add_sel,
    input  logic [2:0]                        shed_sel,
    output logic                              pwm_mode,
    output logic [$clog2(MAX_PHASES+1)-1:0]   phase_cnt
);

    localparam int PH_W  = $clog2(MAX_PHASES + 1);
    localparam int PRD_W = TH_W + PH_W;
    localparam int CMP_W = ((LOAD_W > PRD_W) ? LOAD_W : PRD_W) + 1;
    localparam logic [PH_W-1:0] PH_ONE = PH_W'(1);
    localparam logic [PH_W-1:0] PH_MAX = PH_W'(MAX_PHASES);

    typedef struct packed {
        logic            pwm;
        logic [PH_W-1:0] phases;
    } ctrl_t;

    ctrl_t st_d, st_q;

    thresholds_t      thr;
    logic [CMP_W-1:0] add_lim, shed_lim;
    logic [CMP_W-1:0] load_ext;

    logic [N_FLT-1:0] f_req, f_block, f_restart, f_fire;

    thr_decode u_thr (
        .exit_sel  (exit_sel),
        .entry_sel (entry_sel),
        .add_sel   (add_sel),
        .shed_sel  (shed_sel),
        .thr       (thr)
    );

    phase_scaler #(
        .PH_W  (PH_W),
        .CMP_W (CMP_W)
    ) u_scale (
        .add_ma   (thr.add_ma),
        .shed_ma  (thr.shed_ma),
        .n_phases (st_q.phases),
        .add_lim  (add_lim),
        .shed_lim (shed_lim)
    );

    // Requests and filter controls
    always_comb begin
        load_ext = CMP_W'(load_ma);

        f_req[FLT_MODE] = st_q.pwm ? (load_ext < CMP_W'(thr.entry_ma))
                                   : (load_ext > CMP_W'(thr.exit_ma));
        f_req[FLT_ADD]  = (st_q.phases < PH_MAX) && (load_ext >= add_lim);
        f_req[FLT_SHED] = (st_q.phases > PH_ONE) && (load_ext < shed_lim);

        f_block[FLT_MODE] = !enable || force_pwm;
        f_block[FLT_ADD]  = !enable || !st_q.pwm;
        f_block[FLT_SHED] = !enable || !st_q.pwm;

        f_restart[FLT_MODE] = 1'b0;
        f_restart[FLT_ADD]  = f_fire[FLT_MODE] || f_fire[FLT_SHED];
        f_restart[FLT_SHED] = f_fire[FLT_MODE] || f_fire[FLT_ADD];
    end

    for (genvar gi = 0; gi < N_FLT; gi++) begin : g_flt
        qual_filter #(
            .QUAL_TICKS (QUAL_TICKS)
        ) u_flt (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .req     (f_req[gi]),
            .block   (f_block[gi]),
            .restart (f_restart[gi]),
            .fire    (f_fire[gi])
        );
    end

    // Next state: disable > force > mode change > add > shed
    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.pwm    = force_pwm;
            st_d.phases = PH_ONE;
        end else if (force_pwm && !st_q.pwm) begin
            st_d.pwm = 1'b1;
        end else if (f_fire[FLT_MODE]) begin
            st_d.pwm    = !st_q.pwm;
            st_d.phases = PH_ONE;
        end else if (f_fire[FLT_ADD]) begin
            st_d.phases = st_q.phases + PH_ONE;
        end else if (f_fire[FLT_SHED]) begin
            st_d.phases = st_q.phases - PH_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pwm    <= 1'b0;
            st_q.phases <= PH_ONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_mode  = st_q.pwm;
    assign phase_cnt = st_q.phases;

endmodule

// File: rtl/phase_mode_ctrl_chk.sv
module phase_mode_ctrl_chk #(
    parameter int MAX_PHASES = 6,
    parameter int PH_W       = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enable,
    input logic            tick,
    input logic            force_pwm,
    input logic            pwm_mode,
    input logic [PH_W-1:0] phase_cnt
);

    p_count_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_cnt >= PH_W'(1)) && (phase_cnt <= PH_W'(MAX_PHASES)));

    p_single_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phase_cnt == $past(phase_cnt)) ||
                 (phase_cnt == PH_W'($past(phase_cnt) + PH_W'(1))) ||
                 (phase_cnt == PH_W'($past(phase_cnt) - PH_W'(1))) ||
                 (phase_cnt == PH_W'(1)));

    p_force_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        force_pwm |=> pwm_mode);

    p_pfm_one_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_mode |-> (phase_cnt == PH_W'(1)));

    p_disable_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (phase_cnt == PH_W'(1)) && (pwm_mode == $past(force_pwm)));

    p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick && !force_pwm) |=> $stable(phase_cnt) && $stable(pwm_mode));

endmodule

bind phase_mode_ctrl phase_mode_ctrl_chk #(
    .MAX_PHASES (MAX_PHASES),
    .PH_W       (PH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .tick      (tick),
    .force_pwm (force_pwm),
    .pwm_mode  (pwm_mode),
    .phase_cnt (phase_cnt)
);

// File: tb/phase_mode_ctrl_test.sv
module phase_mode_ctrl_test;

    localparam int QT = 16;
    localparam int NP = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        tick = 1'b0;
    logic        force_pwm = 1'b0;
    logic [13:0] load_ma = '0;
    logic [2:0]  exit_sel = 3'd3;
    logic [2:0]  entry_sel = 3'd0;
    logic [2:0]  add_sel = 3'd2;
    logic [2:0]  shed_sel = 3'd0;
    logic        pwm_mode;
    logic [2:0]  phase_cnt;

    always #2 clk = ~clk;

    phase_mode_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tick      (tick),
        .force_pwm (force_pwm),
        .load_ma   (load_ma),
        .exit_sel  (exit_sel),
        .entry_sel (entry_sel),
        .add_sel   (add_sel),
        .shed_sel  (shed_sel),
        .pwm_mode  (pwm_mode),
        .phase_cnt (phase_cnt)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        int    pwm;
        int    ph;
        string req;
    } exp_t;
    exp_t q[$];

    // Reference state, tick-level
    int m_pwm = 0, m_ph = 1, cm = 0, ca = 0, cs = 0;

    function automatic int exit_of(logic [2:0] c);
        case (c)
            3'd4: return 225;
            3'd5: return 275;
            3'd6: return 325;
            3'd7: return 375;
            default: return 175;
        endcase
    endfunction

    function automatic int entry_of(logic [2:0] c);
        case (c)
            3'd0: return 100;
            3'd1: return 125;
            3'd2: return 150;
            3'd3: return 175;
            default: return 225;
        endcase
    endfunction

    function automatic int add_of(logic [2:0] c);
        case (c)
            3'd3: return 600;
            3'd4: return 700;
            3'd5: return 800;
            3'd6: return 900;
            3'd7: return 1000;
            default: return 500;
        endcase
    endfunction

    function automatic int shed_of(logic [2:0] c);
        case (c)
            3'd0: return 300;
            3'd1: return 400;
            3'd2: return 500;
            3'd3: return 600;
            3'd4: return 700;
            default: return 800;
        endcase
    endfunction

    function automatic void model_idle();
        m_pwm = force_pwm ? 1 : 0;
        m_ph  = 1;
        cm = 0; ca = 0; cs = 0;
    endfunction

    function automatic void model_tick(int ld);
        bit mreq, fm, areq, sreq, fa, fs;
        int per;
        if (!enable) begin
            model_idle();
            return;
        end
        fm = 1'b0;
        if (force_pwm) begin
            cm = 0;
        end else begin
            mreq = (m_pwm != 0) ? (ld < entry_of(entry_sel)) : (ld > exit_of(exit_sel));
            fm   = mreq && (cm == QT - 1);
            cm   = (fm || !mreq) ? 0 : cm + 1;
        end
        per  = ld / m_ph;
        areq = (m_pwm != 0) && (m_ph < NP) && (per > add_of(add_sel));
        sreq = (m_pwm != 0) && (m_ph > 1) && (per < shed_of(shed_sel));
        fa   = areq && (ca == QT - 1);
        fs   = sreq && (cs == QT - 1);
        if ((m_pwm == 0) || fm || fa || fs) begin
            ca = 0; cs = 0;
        end else begin
            ca = areq ? ca + 1 : 0;
            cs = sreq ? cs + 1 : 0;
        end
        if (fm) begin
            m_pwm = (m_pwm != 0) ? 0 : 1;
            m_ph  = 1;
        end else if (fa) begin
            m_ph = m_ph + 1;
        end else if (fs) begin
            m_ph = m_ph - 1;
        end
    endfunction

    function automatic void compare(int pwm_e, int ph_e, string req);
        checks++;
        if ((int'(pwm_mode) != pwm_e) || (int'(phase_cnt) != ph_e)) begin
            fails++;
            $display("FAIL %s: pwm_mode=%0d phase_cnt=%0d expected pwm_mode=%0d phase_cnt=%0d",
                     req, pwm_mode, phase_cnt, pwm_e, ph_e);
        end
    endfunction

    // Monitor: one result per tick, sampled 1 ns after the edge that took it
    always @(posedge clk) begin
        if (tick === 1'b1) begin
            exp_t e;
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                compare(e.pwm, e.ph, e.req);
            end
        end
    end

    task automatic tick_load(int ld, string req);
        exp_t e;
        @(negedge clk);
        load_ma = 14'(ld);
        tick    = 1'b1;
        model_tick(ld);
        e.pwm = m_pwm;
        e.ph  = m_ph;
        e.req = req;
        q.push_back(e);
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic ticks(int n, int ld, string req);
        for (int i = 0; i < n; i++)
            tick_load(ld, req);
    endtask

    task automatic check_now(int pwm_e, int ph_e, string req);
        @(negedge clk);
        compare(pwm_e, ph_e, req);
    endtask

    task automatic set_force(bit v);
        @(negedge clk);
        force_pwm = v;
        if (enable && v) begin
            m_pwm = 1;
            cm    = 0;
        end
        if (!enable)
            model_idle();
    endtask

    task automatic set_enable(bit v);
        @(negedge clk);
        enable = v;
        if (!v)
            model_idle();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_now(0, 1, "R1");
        enable = 1'b1;

        // R3 boundary: exactly at the 175 mA exit level does not count
        ticks(20, 175, "R3");
        check_now(0, 1, "R3");

        // R5: a failing tick restarts, idle cycles do not count
        ticks(10, 200, "R5");
        ticks(1, 150, "R5");
        ticks(15, 200, "R5");
        check_now(0, 1, "R5");
        @(negedge clk);
        load_ma = 14'd900;
        repeat (6) @(negedge clk);
        check_now(0, 1, "R5");
        ticks(1, 200, "R3");
        check_now(1, 1, "R3");

        // R6: add phases on per-phase current
        ticks(15, 1200, "R6");
        check_now(1, 1, "R6");
        ticks(1, 1200, "R6");
        check_now(1, 2, "R6");
        ticks(16, 1200, "R6");
        check_now(1, 3, "R6");
        ticks(20, 1200, "R6");
        check_now(1, 3, "R6");

        // R8: climb to the ceiling and stay there
        ticks(16 * 3, 6000, "R8");
        check_now(1, 6, "R8");
        ticks(20, 6000, "R8");
        check_now(1, 6, "R8");

        // R7: shed one, exactly 300 mA per phase holds
        ticks(16, 1500, "R7");
        check_now(1, 5, "R7");
        ticks(20, 1500, "R7");
        check_now(1, 5, "R7");

        // R6 boundary: 500 per phase does not add, clamped code 000 = 500 mA
        ticks(20, 2504, "R6");
        check_now(1, 5, "R6");
        add_sel = 3'd0;
        ticks(16, 2505, "R6");
        check_now(1, 6, "R6");

        // R7 clamp: shed code 111 = 800 mA, add code 111 = 1000 mA
        shed_sel = 3'd7;
        add_sel  = 3'd7;
        ticks(32, 3750, "R7");
        check_now(1, 4, "R7");
        ticks(20, 3750, "R7");
        check_now(1, 4, "R7");

        // R8: add and shed qualify together, add wins
        add_sel  = 3'd2;
        shed_sel = 3'd5;
        ticks(16, 2400, "R8");
        check_now(1, 5, "R8");

        // R4 with entry clamp 111 = 225 mA; mode return beats a shed
        entry_sel = 3'd7;
        shed_sel  = 3'd0;
        add_sel   = 3'd7;
        ticks(15, 224, "R4");
        check_now(1, 5, "R4");
        ticks(1, 224, "R4");
        check_now(0, 1, "R4");
        ticks(10, 170, "R9");
        check_now(0, 1, "R9");

        // R3 clamp: exit code 000 = 175 mA
        exit_sel = 3'd0;
        ticks(16, 176, "R3");
        check_now(1, 1, "R3");

        // R4 at entry code 100 = 225 mA, then R2 forced PWM
        entry_sel = 3'd4;
        ticks(16, 100, "R4");
        check_now(0, 1, "R4");
        set_force(1'b1);
        check_now(1, 1, "R2");
        ticks(24, 0, "R2");
        check_now(1, 1, "R2");
        set_force(1'b0);

        // R1: disable returns to idle, follows force, ignores ticks
        add_sel = 3'd2;
        ticks(16, 6000, "R6");
        check_now(1, 2, "R6");
        set_enable(1'b0);
        check_now(0, 1, "R1");
        set_force(1'b1);
        check_now(1, 1, "R1");
        ticks(5, 6000, "R1");
        check_now(1, 1, "R1");
        set_force(1'b0);
        check_now(0, 1, "R1");

        repeat (4) @(negedge clk);
        if (q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: %0d results never seen, expected 0", q.size());
        end
        done = 1'b1;
        finish_run();
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            finish_run();
        end
    end

endmodule